// File: doc/BRIEF.md
# Trap and Return Controller for a 32-bit Soft Processor

This block decides how the processor state changes when a fault, a system call, a debug break or an interrupt is taken, and when software returns from a handler. Each cycle it looks at the event strobes and the program counter of the instruction being retired. When an event is taken it does three things. It redirects fetch to a vector address. It writes the faulting program counter into one link entry of the register file. It updates the interrupt enable register so that the previous enable can be restored later.

Ordinary traps and debug breaks are kept apart. Each has its own vector base, its own link register and its own saved-enable bit. A return through a link register restores the matching saved bit. Software reaches the enable, mask, pending and base registers through a small write port. The pending register is write-one-to-clear, and its bits are set by level-sensitive interrupt lines.

Top module: `trap_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output is zero: `redir_valid_o`, `redir_pc_o`, `cause_o`, `rf_we_o`, `rf_addr_o`, `rf_wdata_o`, `irq_enable_o` and `irq_pend_o`.
- R2: A taken event asserts `redir_valid_o` for one cycle, on the clock edge after the event. `redir_pc_o` is then base + cause×32. The base is the debug base for a break and the trap base for every other event. The cause codes are: break 1, data bus error 4, divide by zero 5, interrupt 6, system call 7. In cycles with no event, `redir_pc_o`, `cause_o`, `rf_addr_o` and `rf_wdata_o` are zero.
- R3: With the redirect, `rf_we_o` pulses and `rf_wdata_o` carries the `cur_pc_i` of the event cycle. `rf_addr_o` is 30 for ordinary traps and 31 for a break.
- R4: On an ordinary trap, the enable register becomes {0, old bit 0, 0}.
- R5: On a break, the enable register becomes {old bit 0, 0, 0}.
- R6: A return through register 30 sets the enable register to {0, 0, old bit 1}. A return through register 31 sets it to {0, 0, old bit 2}. A return through any other register leaves it unchanged.
- R7: A CSR write with `csr_sel_i` = 2 (pending) clears each pending bit written with 1 and leaves bits written with 0 unchanged. The other selects load the value directly: 0 enable (low 3 bits), 1 mask, 3 trap base, 4 debug base. Selects 5 to 7 change nothing.
- R8: `div_req_i` with a zero `divisor_i` raises divide by zero. With a nonzero divisor there is no event.
- R9: `bus_unmapped_i` and `bus_misalign_i` each raise the data bus error on their own.
- R10: When several events fall in the same cycle, only one is taken. The order, highest first, is: data bus error, divide by zero, system call, break, interrupt.
- R11: Each cycle, a high interrupt line sets its pending bit, and this set wins over a clear in the same cycle. An interrupt is taken when enable bit 0 is 1 and pending AND mask is nonzero.
- R12: In a cycle where an event is taken, the return strobe and any CSR write are discarded. Without an event, a return takes precedence over a CSR write to the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc_i | input | 32 | Program counter of the retiring instruction |
| div_req_i | input | 1 | Unsigned divide or modulo in flight |
| divisor_i | input | 32 | Divisor operand of that operation |
| scall_i | input | 1 | System call strobe |
| break_i | input | 1 | Debug break strobe |
| bus_unmapped_i | input | 1 | Data access hit no mapped region |
| bus_misalign_i | input | 1 | Data access was misaligned |
| irq_lines_i | input | 8 | Level interrupt lines |
| ret_valid_i | input | 1 | Register-indirect branch (return) strobe |
| ret_reg_i | input | 5 | Register named by that branch |
| csr_we_i | input | 1 | Control register write strobe |
| csr_sel_i | input | 3 | Control register select |
| csr_wdata_i | input | 32 | Control register write data |
| redir_valid_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect target |
| cause_o | output | 3 | Cause code of the taken event |
| rf_we_o | output | 1 | Link write enable |
| rf_addr_o | output | 5 | Link register index |
| rf_wdata_o | output | 32 | Saved program counter |
| irq_enable_o | output | 3 | Interrupt enable register |
| irq_pend_o | output | 8 | Interrupt pending register |

## Verification
Every result is due one clock edge after its stimulus. This covers the redirect, the link write, the cause code and the new enable and pending values, because all of them come straight out of registers. The one exception is an interrupt line: it first sets its pending bit, and only on the following edge can that bit cause the interrupt to be taken, so that path takes two edges. The bench drives each stimulus just after a falling edge. It then passes the same stimulus to its own reference model, waits through one rising edge, and compares every output with the model at the next falling edge, so a result is always read in the cycle it is due.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int IE_W       = 3;
  localparam int SLOT_SHIFT = 5;
  localparam int NSRC       = 5;
  localparam int SRC_W      = $clog2(NSRC);

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_BREAK = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIVZ  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } exc_id_e;

  typedef enum logic [2:0] {
    CSR_ENABLE = 3'd0,
    CSR_MASK   = 3'd1,
    CSR_PEND   = 3'd2,
    CSR_TBASE  = 3'd3,
    CSR_DBASE  = 3'd4
  } csr_sel_e;

  // request slots, lowest index = highest priority
  localparam int SRC_DBUS  = 0;
  localparam int SRC_DIVZ  = 1;
  localparam int SRC_SCALL = 2;
  localparam int SRC_BREAK = 3;
  localparam int SRC_IRQ   = 4;

  function automatic exc_id_e src_to_cause(input logic [SRC_W-1:0] s);
    case (s)
      SRC_W'(SRC_DBUS):  return EXC_DBUS;
      SRC_W'(SRC_DIVZ):  return EXC_DIVZ;
      SRC_W'(SRC_SCALL): return EXC_SCALL;
      SRC_W'(SRC_BREAK): return EXC_BREAK;
      default:           return EXC_IRQ;
    endcase
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int N     = 5,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic            any_o
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = IDXW'(i);
    end
  end

  assign any_o = |req_i;

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o)) else $error("grant not one-hot"); // R10
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |-> ($countones(grant_o) == 1 && (grant_o & ~req_i) == '0))
    else $error("grant lost or stray"); // R10
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NIRQ      = 8,
  parameter int          RF_AW     = 5,
  parameter int          LINK_EXC  = 30,
  parameter int          LINK_DBG  = 31,
  parameter logic [31:0] TBASE_RST = 32'h0,
  parameter logic [31:0] DBASE_RST = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             dbg_i,
  input  logic             ret_i,
  input  logic [RF_AW-1:0] ret_reg_i,
  input  logic             wr_i,
  input  logic [2:0]       sel_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [NIRQ-1:0]  irq_i,
  output logic [IE_W-1:0]  ie_o,
  output logic [NIRQ-1:0]  im_o,
  output logic [NIRQ-1:0]  ip_o,
  output logic [XLEN-1:0]  tbase_o,
  output logic [XLEN-1:0]  dbase_o
);
  logic [NIRQ-1:0] clr_mask;
  logic            ret_exc, ret_dbg;

  assign ret_exc  = ret_i && (ret_reg_i == RF_AW'(LINK_EXC));
  assign ret_dbg  = ret_i && (ret_reg_i == RF_AW'(LINK_DBG));
  assign clr_mask = (wr_i && sel_i == CSR_PEND) ? wdata_i[NIRQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_o <= '0;
    end else if (take_i) begin
      ie_o <= dbg_i ? {ie_o[0], 2'b00} : {1'b0, ie_o[0], 1'b0};
    end else if (ret_exc) begin
      ie_o <= {2'b00, ie_o[1]};
    end else if (ret_dbg) begin
      ie_o <= {2'b00, ie_o[2]};
    end else if (wr_i && sel_i == CSR_ENABLE) begin
      ie_o <= wdata_i[IE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      im_o    <= '0;
      tbase_o <= XLEN'(TBASE_RST);
      dbase_o <= XLEN'(DBASE_RST);
    end else if (wr_i) begin
      if (sel_i == CSR_MASK)  im_o    <= wdata_i[NIRQ-1:0];
      if (sel_i == CSR_TBASE) tbase_o <= wdata_i;
      if (sel_i == CSR_DBASE) dbase_o <= wdata_i;
    end
  end

  for (genvar b = 0; b < NIRQ; b++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) ip_o[b] <= 1'b0;
      else     ip_o[b] <= irq_i[b] | (ip_o[b] & ~clr_mask[b]);
    end
  end

  AST_IE_SAVE_EXC: assert property (@(posedge clk) disable iff (rst)
    (take_i && !dbg_i) |=> ie_o == {1'b0, $past(ie_o[0]), 1'b0})
    else $error("enable save on trap"); // R4
  AST_IE_SAVE_DBG: assert property (@(posedge clk) disable iff (rst)
    (take_i && dbg_i) |=> ie_o == {$past(ie_o[0]), 2'b00})
    else $error("enable save on break"); // R5
  AST_IE_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (!take_i && ret_exc) |=> ie_o == {2'b00, $past(ie_o[1])})
    else $error("enable restore"); // R6
  AST_PEND_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (|irq_i) |=> (ip_o & $past(irq_i)) == $past(irq_i))
    else $error("pending set lost"); // R11
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NIRQ      = 8,
  parameter int          RF_AW     = 5,
  parameter int          LINK_EXC  = 30,
  parameter int          LINK_DBG  = 31,
  parameter logic [31:0] TBASE_RST = 32'h0,
  parameter logic [31:0] DBASE_RST = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic             div_req_i,
  input  logic [XLEN-1:0]  divisor_i,
  input  logic             scall_i,
  input  logic             break_i,
  input  logic             bus_unmapped_i,
  input  logic             bus_misalign_i,
  input  logic [NIRQ-1:0]  irq_lines_i,
  input  logic             ret_valid_i,
  input  logic [RF_AW-1:0] ret_reg_i,
  input  logic             csr_we_i,
  input  logic [2:0]       csr_sel_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic             redir_valid_o,
  output logic [XLEN-1:0]  redir_pc_o,
  output logic [2:0]       cause_o,
  output logic             rf_we_o,
  output logic [RF_AW-1:0] rf_addr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic [IE_W-1:0]  irq_enable_o,
  output logic [NIRQ-1:0]  irq_pend_o
);
  logic [NSRC-1:0]  req, grant;
  logic [SRC_W-1:0] win_idx;
  logic             taken, is_dbg;
  exc_id_e          cause;
  logic [NIRQ-1:0]  im_q;
  logic [XLEN-1:0]  tbase_q, dbase_q, base, target;

  always_comb begin
    req            = '0;
    req[SRC_DBUS]  = bus_unmapped_i | bus_misalign_i;
    req[SRC_DIVZ]  = div_req_i && (divisor_i == '0);
    req[SRC_SCALL] = scall_i;
    req[SRC_BREAK] = break_i;
    req[SRC_IRQ]   = irq_enable_o[0] && (|(irq_pend_o & im_q));
  end

  trap_arbiter #(.N(NSRC)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (taken)
  );

  assign is_dbg = grant[SRC_BREAK];
  assign cause  = src_to_cause(win_idx);
  assign base   = is_dbg ? dbase_q : tbase_q;
  assign target = base + (XLEN'(cause) << SLOT_SHIFT);

  trap_csr_bank #(
    .XLEN(XLEN), .NIRQ(NIRQ), .RF_AW(RF_AW),
    .LINK_EXC(LINK_EXC), .LINK_DBG(LINK_DBG),
    .TBASE_RST(TBASE_RST), .DBASE_RST(DBASE_RST)
  ) u_csr (
    .clk       (clk),
    .rst       (rst),
    .take_i    (taken),
    .dbg_i     (is_dbg),
    .ret_i     (ret_valid_i & ~taken),
    .ret_reg_i (ret_reg_i),
    .wr_i      (csr_we_i & ~taken),
    .sel_i     (csr_sel_i),
    .wdata_i   (csr_wdata_i),
    .irq_i     (irq_lines_i),
    .ie_o      (irq_enable_o),
    .im_o      (im_q),
    .ip_o      (irq_pend_o),
    .tbase_o   (tbase_q),
    .dbase_o   (dbase_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      cause_o       <= '0;
      rf_we_o       <= 1'b0;
      rf_addr_o     <= '0;
      rf_wdata_o    <= '0;
    end else begin
      redir_valid_o <= taken;
      rf_we_o       <= taken;
      redir_pc_o    <= taken ? target : '0;
      cause_o       <= taken ? cause : 3'd0;
      rf_wdata_o    <= taken ? cur_pc_i : '0;
      rf_addr_o     <= !taken ? '0 : (is_dbg ? RF_AW'(LINK_DBG) : RF_AW'(LINK_EXC));
    end
  end

  AST_LINK_MATCH: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> ((rf_addr_o == RF_AW'(LINK_DBG)) == (cause_o == EXC_BREAK)))
    else $error("link register mismatch"); // R3
  AST_SAVED_PC: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_wdata_o == $past(cur_pc_i))
    else $error("saved pc wrong"); // R3
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (rst)
    redir_valid_o |-> (redir_pc_o - ((cause_o == EXC_BREAK) ? dbase_q : tbase_q))
                      == (XLEN'(cause_o) << SLOT_SHIFT))
    else $error("vector slot wrong"); // R2
  AST_DIVZ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (redir_valid_o && cause_o == EXC_DIVZ) |-> $past(div_req_i && divisor_i == '0))
    else $error("spurious divide trap"); // R8
endmodule

// File: tb/trap_unit_test.sv
module trap_unit_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NIRQ       = 8;
  localparam logic [31:0] TB_RST     = 32'h0000_0000;
  localparam logic [31:0] DB_RST     = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cur_pc = '0, divisor = '0, csr_wdata = '0;
  logic        div_req = 0, scall = 0, brk = 0, unm = 0, mis = 0;
  logic [NIRQ-1:0] irq = '0;
  logic        ret_valid = 0, csr_we = 0;
  logic [4:0]  ret_reg = '0;
  logic [2:0]  csr_sel = '0;

  logic        redir_valid, rf_we;
  logic [31:0] redir_pc, rf_wdata;
  logic [2:0]  cause, ie;
  logic [4:0]  rf_addr;
  logic [NIRQ-1:0] pend;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state and expectations
  logic [2:0]      m_ie;
  logic [NIRQ-1:0] m_im, m_ip;
  logic [31:0]     m_tb, m_db;
  logic            e_rv;
  logic [31:0]     e_rpc, e_wd;
  logic [2:0]      e_cause;
  logic [4:0]      e_wa;
  string           t_r, t_ie, t_ip;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_unit #(.NIRQ(NIRQ), .TBASE_RST(TB_RST), .DBASE_RST(DB_RST)) uut (
    .clk(clk), .rst(rst), .cur_pc_i(cur_pc), .div_req_i(div_req), .divisor_i(divisor),
    .scall_i(scall), .break_i(brk), .bus_unmapped_i(unm), .bus_misalign_i(mis),
    .irq_lines_i(irq), .ret_valid_i(ret_valid), .ret_reg_i(ret_reg),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc), .cause_o(cause),
    .rf_we_o(rf_we), .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata),
    .irq_enable_o(ie), .irq_pend_o(pend)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ie = '0; m_im = '0; m_ip = '0; m_tb = TB_RST; m_db = DB_RST;
    e_rv = 0; e_rpc = '0; e_wd = '0; e_cause = '0; e_wa = '0;
    t_r = "R1"; t_ie = "R1"; t_ip = "R1";
  endtask

  task automatic model_step();
    logic dbus, divz, irq_ok;
    int src, nreq;
    logic [NIRQ-1:0] clr;
    dbus   = unm | mis;
    divz   = div_req && (divisor == 0);
    irq_ok = m_ie[0] && ((m_ip & m_im) != 0);
    nreq   = int'(dbus) + int'(divz) + int'(scall) + int'(brk) + int'(irq_ok);
    src = -1;
    if (dbus) src = 0; else if (divz) src = 1; else if (scall) src = 2;
    else if (brk) src = 3; else if (irq_ok) src = 4;
    case (src)
      0: e_cause = 3'd4;
      1: e_cause = 3'd5;
      2: e_cause = 3'd7;
      3: e_cause = 3'd1;
      4: e_cause = 3'd6;
      default: e_cause = 3'd0;
    endcase
    t_r = "R2";
    if (nreq > 1) t_r = "R10";
    else if (src == 0) t_r = "R9";
    else if (src == 1 || div_req) t_r = "R8";
    else if (src == 4) t_r = "R11";
    e_rv  = (src >= 0);
    e_rpc = !e_rv ? 32'h0 : ((src == 3 ? m_db : m_tb) + ({29'd0, e_cause} << 5));
    e_wa  = !e_rv ? 5'd0 : (src == 3 ? 5'd31 : 5'd30);
    e_wd  = e_rv ? cur_pc : 32'h0;
    t_ie = "R7";
    clr  = '0;
    if (e_rv) begin
      t_ie = (src == 3) ? "R5" : "R4";
      if (ret_valid || csr_we) t_ie = "R12";
      m_ie = (src == 3) ? {m_ie[0], 2'b00} : {1'b0, m_ie[0], 1'b0};
    end else begin
      if (ret_valid) begin
        t_ie = csr_we ? "R12" : "R6";
        if (ret_reg == 5'd30) m_ie = {2'b00, m_ie[1]};
        else if (ret_reg == 5'd31) m_ie = {2'b00, m_ie[2]};
        else if (csr_we && csr_sel == 3'd0) m_ie = csr_wdata[2:0];
      end else if (csr_we && csr_sel == 3'd0) m_ie = csr_wdata[2:0];
      if (csr_we) begin
        case (csr_sel)
          3'd1: m_im = csr_wdata[NIRQ-1:0];
          3'd2: clr  = csr_wdata[NIRQ-1:0];
          3'd3: m_tb = csr_wdata;
          3'd4: m_db = csr_wdata;
          default: ;
        endcase
      end
    end
    t_ip = (clr != 0) ? "R7" : "R11";
    m_ip = (m_ip & ~clr) | irq;
  endtask

  task automatic compare_all();
    chk(t_r, "redirect valid", {31'd0, redir_valid}, {31'd0, e_rv});
    chk(t_r, "redirect pc", redir_pc, e_rpc);
    chk(t_r, "cause", {29'd0, cause}, {29'd0, e_cause});
    chk("R3", "link we", {31'd0, rf_we}, {31'd0, e_rv});
    chk("R3", "link addr", {27'd0, rf_addr}, {27'd0, e_wa});
    chk("R3", "link data", rf_wdata, e_wd);
    chk(t_ie, "enable", {29'd0, ie}, {29'd0, m_ie});
    chk(t_ip, "pending", {24'd0, pend}, {24'd0, m_ip});
  endtask

  task automatic idle();
    div_req = 0; divisor = 32'd1; scall = 0; brk = 0; unm = 0; mis = 0;
    irq = '0; ret_valid = 0; ret_reg = '0; csr_we = 0; csr_sel = '0; csr_wdata = '0;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic wr_csr(logic [2:0] s, logic [31:0] d);
    csr_we = 1; csr_sel = s; csr_wdata = d; cycle();
  endtask

  task automatic ret_via(logic [4:0] r);
    ret_valid = 1; ret_reg = r; cycle();
  endtask

  initial begin
    void'($urandom(32'd20240517));
    idle();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare_all();                        // R1 reset state
    @(posedge clk);
    @(negedge clk);
    compare_all();                        // R1 first cycle after reset

    // R7 setup of bases, mask, enable
    wr_csr(3'd3, 32'h0000_0100);
    wr_csr(3'd4, 32'h0000_2000);
    wr_csr(3'd1, 32'h0000_00FF);
    wr_csr(3'd0, 32'h0000_0001);
    wr_csr(3'd6, 32'hFFFF_FFFF);          // R7 unused select
    // R8 zero divisor traps, nonzero does not
    cur_pc = 32'h0000_4000; div_req = 1; divisor = 0; cycle();
    ret_via(5'd30);                       // R6
    div_req = 1; divisor = 32'd7; cycle();
    // R5 break then R6 return through 31
    cur_pc = 32'h0000_4010; brk = 1; cycle();
    ret_via(5'd31);
    ret_via(5'd7);                        // R6 other register
    // R9 both bus faults
    unm = 1; cycle(); ret_via(5'd30);
    mis = 1; cycle(); ret_via(5'd30);
    // R10 priority ladder
    unm = 1; div_req = 1; divisor = 0; scall = 1; brk = 1; cycle(); ret_via(5'd30);
    div_req = 1; divisor = 0; scall = 1; brk = 1; cycle(); ret_via(5'd30);
    scall = 1; brk = 1; cycle(); ret_via(5'd30);
    // R11 interrupt path with clear and set-wins
    irq = 8'h08; cycle();
    cycle();
    wr_csr(3'd2, 32'h0000_0008);
    ret_via(5'd30);
    irq = 8'h04; csr_we = 1; csr_sel = 3'd2; csr_wdata = 32'h4; cycle();
    wr_csr(3'd1, 32'h0);
    wr_csr(3'd0, 32'h1);
    wr_csr(3'd2, 32'hFF);
    // R12 event swallows CSR write and return
    wr_csr(3'd1, 32'hFF);
    scall = 1; csr_we = 1; csr_sel = 3'd3; csr_wdata = 32'h0000_9000; cycle();
    brk = 1; ret_valid = 1; ret_reg = 5'd30; cycle();
    ret_valid = 1; ret_reg = 5'd31; csr_we = 1; csr_sel = 3'd0; csr_wdata = 32'h7; cycle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      cur_pc  = $urandom() & 32'hFFFF_FFFC;
      div_req = ($urandom_range(0, 9) == 0);
      divisor = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom();
      scall   = ($urandom_range(0, 19) == 0);
      brk     = ($urandom_range(0, 19) == 0);
      unm     = ($urandom_range(0, 29) == 0);
      mis     = ($urandom_range(0, 29) == 0);
      irq     = ($urandom_range(0, 7) == 0) ? NIRQ'($urandom()) : '0;
      ret_valid = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 2))
        0: ret_reg = 5'd30;
        1: ret_reg = 5'd31;
        default: ret_reg = 5'($urandom());
      endcase
      csr_we    = ($urandom_range(0, 3) == 0);
      csr_sel   = 3'($urandom());
      csr_wdata = $urandom();
      cycle();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule